// File: doc/BRIEF.md
# Multi-Comparator Event Timer

This block keeps time for a chip with one free-running 64-bit main counter and a small set of comparator timers. Software reaches it through a 32-bit register bus with separate write and read strobes, a byte address and a data word. A global run bit starts and stops the main counter. Each timer compares its own 64-bit comparator with the counter. When the two are equal and the timer's interrupt enable is set, the timer raises an interrupt.

Each timer picks its interrupt style. In edge style the line pulses for exactly the match cycle, and nothing has to be acknowledged. In level style the match sets a sticky status bit that drives the line until software writes a 1 to that bit. Timer 0 can also run periodically: each match advances its comparator by the programmed period, so the interrupts stay evenly spaced. Any timer can be narrowed to 32 bits. Software can read the counter and the comparators at any time to measure elapsed time or the time left. Stopping the counter lets software read both halves without a carry from the low half into the high half between the two reads.

Top module: `evt_timer`

## Requirements
- R1: After reset every register reads 0, the counter is stopped and all interrupt lines are low. Addresses that map to no register read 0, and `rdata` is 0 whenever `rd_en` is low.
- R2: While bit 0 of the global word (0x00) is 1, the counter grows by exactly 1 per clock, with carry from the low half into the high half. While that bit is 0 the counter holds its value. The low half reads at 0x10 and the high half at 0x14.
- R3: Writes to 0x10 and 0x14 load the counter halves only while the counter is stopped. While it runs, such writes are ignored.
- R4: A match event happens in a cycle where the counter is running, the timer's interrupt enable (config bit 0) is 1, and the counter equals the comparator. A stopped counter or a cleared enable gives no event, no interrupt and no status.
- R5: Edge style (config bit 1 = 0): the timer's `irq` bit is high in the match cycle only, and the timer's status bit is not set.
- R6: Level style (config bit 1 = 1): status bit n of 0x08 becomes 1 at the clock edge that ends the match cycle, and `irq[n]` then stays high. A write to 0x08 with bit n = 1 clears it. Bits written as 0 have no effect.
- R7: If a level-style match and a clearing write to the same status bit fall in the same cycle, the bit ends up set.
- R8: Timer 0 supports periodic mode (config bit 2). A comparator write also loads the period. Each match adds the period to the comparator, and the comparator reads back the next match time. On other timers config bit 2 reads 0.
- R9: The 32-bit mode (config bit 3) compares only the low 32 bits, and the comparator high word reads 0 in that mode.
- R10: Timer n's registers sit at 0x20 + 0x10*n: config at offset 0, comparator low at offset 4, comparator high at offset 8. Each reads back what was written, apart from the masking described in R8 and R9.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (combinational read) |
| addr | input | 8 | Byte address of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid in the same cycle as `rd_en` |
| irq | output | NUM_TIMERS | Per-timer interrupt lines |

## Verification
The bench builds the block with its default of three timers. That is enough to run timer 0 periodic, timer 1 in edge style with and without 32-bit mode, and timer 2 in level style, all at the same time on one counter. The bench keeps its own model of the counter and sweeps every cycle of each match window. It compares every interrupt line against the match times it works out itself, including multiples of the period and matches on the low half with a non-zero high half. It times a status clear onto the exact match cycle and loads the counter so that the low half rolls over into the high half during a run.

// File: rtl/evt_pkg.sv
package evt_pkg;
  localparam int CNT_W  = 64;
  localparam int BUS_W  = 32;
  localparam int ADDR_W = 8;

  localparam logic [ADDR_W-1:0] OFS_GCFG       = 8'h00;
  localparam logic [ADDR_W-1:0] OFS_ISTAT      = 8'h08;
  localparam logic [ADDR_W-1:0] OFS_CNT_LO     = 8'h10;
  localparam logic [ADDR_W-1:0] OFS_CNT_HI     = 8'h14;
  localparam int                OFS_TMR_BASE   = 32;
  localparam int                OFS_TMR_STRIDE = 16;
  localparam int                OFS_TCFG       = 0;
  localparam int                OFS_TCMP_LO    = 4;
  localparam int                OFS_TCMP_HI    = 8;

  // config word layout, bit 3 down to bit 0
  typedef struct packed {
    logic narrow;
    logic periodic;
    logic level;
    logic ien;
  } tcfg_t;

  function automatic logic [ADDR_W-1:0] tmr_addr(input int idx, input int ofs);
    return ADDR_W'(OFS_TMR_BASE + idx * OFS_TMR_STRIDE + ofs);
  endfunction

  // restrict a value to the active comparison width
  function automatic logic [CNT_W-1:0] clip(input logic [CNT_W-1:0] v, input logic narrow);
    return narrow ? {{(CNT_W-BUS_W){1'b0}}, v[BUS_W-1:0]} : v;
  endfunction

  function automatic logic hits(input logic [CNT_W-1:0] cnt, input logic [CNT_W-1:0] cmp,
                                input logic narrow);
    return clip(cnt, narrow) == clip(cmp, narrow);
  endfunction

  function automatic logic [CNT_W-1:0] advance(input logic [CNT_W-1:0] cmp,
                                               input logic [CNT_W-1:0] per, input logic narrow);
    return clip(cmp + per, narrow);
  endfunction
endpackage

// File: rtl/evt_main_counter.sv
module evt_main_counter #(
  parameter int W = 64
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           run,
  input  logic           ld_lo,
  input  logic           ld_hi,
  input  logic [W/2-1:0] ld_val,
  output logic [W-1:0]   value
);
  localparam int H = W / 2;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      value <= '0;
    end else if (run) begin
      value <= value + 1'b1;
    end else begin
      if (ld_lo) value[H-1:0] <= ld_val;
      if (ld_hi) value[W-1:H] <= ld_val;
    end
  end
endmodule

// File: rtl/evt_comparator.sv
module evt_comparator
  import evt_pkg::*;
#(
  parameter bit PERIODIC_OK = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [CNT_W-1:0] cnt,
  input  logic             cfg_we,
  input  logic             lo_we,
  input  logic             hi_we,
  input  logic [BUS_W-1:0] wdata,
  input  logic             clr,
  output tcfg_t            cfg,
  output logic [CNT_W-1:0] cmp_view,
  output logic [CNT_W-1:0] per_view,
  output logic             match,
  output logic             status,
  output logic             irq
);
  logic [CNT_W-1:0] cmp_q;
  logic [CNT_W-1:0] per_q;
  tcfg_t            cfg_in;

  always_comb begin
    cfg_in = tcfg_t'(wdata[3:0]);
    if (!PERIODIC_OK) cfg_in.periodic = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      cfg <= '0;
    else if (cfg_we) cfg <= cfg_in;
  end

  assign cmp_view = clip(cmp_q, cfg.narrow);
  assign per_view = clip(per_q, cfg.narrow);
  assign match    = run && cfg.ien && hits(cnt, cmp_q, cfg.narrow);

  // a comparator write also sets the period; a periodic match advances the comparator
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmp_q <= '0;
      per_q <= '0;
    end else begin
      if (lo_we) begin
        cmp_q[BUS_W-1:0] <= wdata;
        per_q[BUS_W-1:0] <= wdata;
      end
      if (hi_we && !cfg.narrow) begin
        cmp_q[CNT_W-1:BUS_W] <= wdata;
        per_q[CNT_W-1:BUS_W] <= wdata;
      end
      if (!lo_we && !hi_we && match && cfg.periodic)
        cmp_q <= advance(cmp_view, per_view, cfg.narrow);
    end
  end

  // a new match takes priority over a clear in the same cycle
  always_ff @(posedge clk) begin
    if (!rst_n)                  status <= 1'b0;
    else if (match && cfg.level) status <= 1'b1;
    else if (clr)                status <= 1'b0;
  end

  assign irq = cfg.level ? status : match;
endmodule

// File: rtl/evt_timer.sv
module evt_timer
  import evt_pkg::*;
#(
  parameter int NUM_TIMERS = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic                  rd_en,
  input  logic [ADDR_W-1:0]     addr,
  input  logic [BUS_W-1:0]      wdata,
  output logic [BUS_W-1:0]      rdata,
  output logic [NUM_TIMERS-1:0] irq
);
  localparam int HALF = CNT_W / 2;

  logic             run_q;
  logic             cnt_wr;
  logic             istat_we;
  logic [CNT_W-1:0] cnt;

  logic [NUM_TIMERS-1:0]            match_v, status_v, level_v, narrow_v, clr_v;
  logic [NUM_TIMERS-1:0][3:0]       cfg_bits;
  logic [NUM_TIMERS-1:0][CNT_W-1:0] cmp_v, per_v;
  logic                             periodic0;

  always_ff @(posedge clk) begin
    if (!rst_n)                         run_q <= 1'b0;
    else if (wr_en && addr == OFS_GCFG) run_q <= wdata[0];
  end

  assign cnt_wr   = wr_en && !run_q && (addr == OFS_CNT_LO || addr == OFS_CNT_HI);
  assign istat_we = wr_en && addr == OFS_ISTAT;

  evt_main_counter #(.W(CNT_W)) u_cnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (run_q),
    .ld_lo  (cnt_wr && addr == OFS_CNT_LO),
    .ld_hi  (cnt_wr && addr == OFS_CNT_HI),
    .ld_val (wdata),
    .value  (cnt)
  );

  for (genvar i = 0; i < NUM_TIMERS; i++) begin : g_tmr
    tcfg_t cfg_i;
    assign clr_v[i] = istat_we && wdata[i];

    evt_comparator #(.PERIODIC_OK(i == 0)) u_cmp (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (run_q),
      .cnt      (cnt),
      .cfg_we   (wr_en && addr == tmr_addr(i, OFS_TCFG)),
      .lo_we    (wr_en && addr == tmr_addr(i, OFS_TCMP_LO)),
      .hi_we    (wr_en && addr == tmr_addr(i, OFS_TCMP_HI)),
      .wdata    (wdata),
      .clr      (clr_v[i]),
      .cfg      (cfg_i),
      .cmp_view (cmp_v[i]),
      .per_view (per_v[i]),
      .match    (match_v[i]),
      .status   (status_v[i]),
      .irq      (irq[i])
    );

    assign cfg_bits[i] = cfg_i;
    assign level_v[i]  = cfg_i.level;
    assign narrow_v[i] = cfg_i.narrow;
  end

  assign periodic0 = cfg_bits[0][2];

  always_comb begin
    rdata = '0;
    if (rd_en) begin
      if (addr == OFS_GCFG)   rdata[0] = run_q;
      if (addr == OFS_ISTAT)  rdata[NUM_TIMERS-1:0] = status_v;
      if (addr == OFS_CNT_LO) rdata = cnt[HALF-1:0];
      if (addr == OFS_CNT_HI) rdata = cnt[CNT_W-1:HALF];
      for (int i = 0; i < NUM_TIMERS; i++) begin
        if (addr == tmr_addr(i, OFS_TCFG))    rdata[3:0] = cfg_bits[i];
        if (addr == tmr_addr(i, OFS_TCMP_LO)) rdata = cmp_v[i][HALF-1:0];
        if (addr == tmr_addr(i, OFS_TCMP_HI)) rdata = cmp_v[i][CNT_W-1:HALF];
      end
    end
  end
endmodule

// File: rtl/evt_timer_chk.sv
module evt_timer_chk
  import evt_pkg::*;
#(
  parameter int N = 3
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  run,
  input logic                  cnt_wr,
  input logic [CNT_W-1:0]      cnt,
  input logic                  wr_en,
  input logic                  rd_en,
  input logic [ADDR_W-1:0]     addr,
  input logic [BUS_W-1:0]      rdata,
  input logic [N-1:0]          match_v,
  input logic [N-1:0]          status_v,
  input logic [N-1:0]          level_v,
  input logic [N-1:0]          narrow_v,
  input logic [N-1:0]          clr_v,
  input logic [CNT_W-1:0]      cmp0,
  input logic [CNT_W-1:0]      per0,
  input logic                  periodic0
);
  logic t0_wr;
  assign t0_wr = wr_en && (addr == tmr_addr(0, OFS_TCFG) || addr == tmr_addr(0, OFS_TCMP_LO) ||
                           addr == tmr_addr(0, OFS_TCMP_HI));

  a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
    run |=> cnt == $past(cnt) + 64'd1);

  a_r3_hold_when_stopped: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !cnt_wr) |=> cnt == $past(cnt));

  a_r4_quiet_when_stopped: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> match_v == '0);

  a_r8_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (match_v[0] && periodic0 && !narrow_v[0] && !t0_wr) |=> (cmp0 - $past(cmp0)) == $past(per0));

  for (genvar i = 0; i < N; i++) begin : g_chk
    a_r6_set: assert property (@(posedge clk) disable iff (!rst_n)
      (match_v[i] && level_v[i]) |=> status_v[i]);

    a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (status_v[i] && !clr_v[i]) |=> status_v[i]);

    a_r7_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (match_v[i] && level_v[i] && clr_v[i]) |=> status_v[i]);

    a_r5_no_latch: assert property (@(posedge clk) disable iff (!rst_n)
      (!level_v[i] && !status_v[i]) |=> !status_v[i]);

    a_r9_hi_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && narrow_v[i] && addr == tmr_addr(i, OFS_TCMP_HI)) |-> rdata == '0);
  end
endmodule

bind evt_timer evt_timer_chk #(.N(NUM_TIMERS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .run       (run_q),
  .cnt_wr    (cnt_wr),
  .cnt       (cnt),
  .wr_en     (wr_en),
  .rd_en     (rd_en),
  .addr      (addr),
  .rdata     (rdata),
  .match_v   (match_v),
  .status_v  (status_v),
  .level_v   (level_v),
  .narrow_v  (narrow_v),
  .clr_v     (clr_v),
  .cmp0      (cmp_v[0]),
  .per0      (per_v[0]),
  .periodic0 (periodic0)
);

// File: tb/tb_evt_timer.sv
module tb_evt_timer;
  localparam int CLK_PERIOD = 10;
  localparam int NT = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic          rd_en = 1'b0;
  logic [7:0]    addr = '0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;
  logic [NT-1:0] irq;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  // bench's own view of the counter, built from R2/R3
  logic [63:0] m_cnt;
  logic        m_en;

  evt_timer #(.NUM_TIMERS(NT)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt <= '0;
      m_en  <= 1'b0;
    end else begin
      if (m_en) m_cnt <= m_cnt + 64'd1;
      else if (wr_en && addr == 8'h10) m_cnt[31:0]  <= wdata;
      else if (wr_en && addr == 8'h14) m_cnt[63:32] <= wdata;
      if (wr_en && addr == 8'h00) m_en <= wdata[0];
    end
  end

  function automatic logic [7:0] ta(input int n, input int ofs);
    return 8'(32 + 16 * n + ofs);
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // called at a falling edge; returns at the next falling edge
  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    rd_en = 1'b1; addr = a;
    #1;
    d = rdata;
    rd_en = 1'b0;
  endtask

  task automatic rd_cnt(output logic [63:0] v);
    logic [31:0] lo, hi;
    rd(8'h10, lo);
    rd(8'h14, hi);
    v = {hi, lo};
  endtask

  task automatic wr_cmp(input int n, input logic [63:0] v);
    wr(ta(n, 8), v[63:32]);
    wr(ta(n, 4), v[31:0]);
  endtask

  task automatic summary;
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic [63:0] v, v2, tgt;
    int mism, pulses;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 / R10: reset state
    mism = 0;
    rd(8'h00, d); if (d !== 0) mism++;
    rd(8'h08, d); if (d !== 0) mism++;
    rd(8'h10, d); if (d !== 0) mism++;
    rd(8'h14, d); if (d !== 0) mism++;
    rd(8'h04, d); if (d !== 0) mism++;
    for (int n = 0; n < NT; n++) begin
      for (int o = 0; o <= 8; o += 4) begin
        rd(ta(n, o), d); if (d !== 0) mism++;
      end
    end
    chk("R1 reset registers zero", mism, 0);
    chk("R1 reset irq low", irq, 0);
    rd_en = 1'b0; addr = 8'h14; #1;
    chk("R1 rdata zero without rd_en", rdata, 0);
    repeat (3) @(negedge clk);
    rd_cnt(v);
    chk("R1 counter stopped after reset", v, 0);

    // R3: loads while stopped
    wr(8'h10, 32'hFFFF_FFF0);
    wr(8'h14, 32'h0000_0002);
    rd_cnt(v);
    chk("R3 load while stopped", v, 64'h2_FFFF_FFF0);

    // R2: run with carry into high half
    wr(8'h00, 32'h1);
    repeat (20) @(negedge clk);
    rd_cnt(v);
    chk("R2 counting with carry", v, 64'h3_0000_0004);
    rd(8'h00, d);
    chk("R10 global word readback", d, 1);

    // R3: loads while running are ignored
    wr(8'h10, 32'h0);
    wr(8'h14, 32'h0);
    rd_cnt(v);
    chk("R3 load ignored while running", v, m_cnt);
    chk("R3 counter still high", v[63:32], 3);

    // R5: edge style on timer 1
    wr(ta(1, 0), 32'h1);
    tgt = m_cnt + 64'd40;
    wr_cmp(1, tgt);
    rd(ta(1, 4), d);
    chk("R10 comparator low readback", d, tgt[31:0]);
    mism = 0; pulses = 0;
    for (int k = 0; k < 60; k++) begin
      @(negedge clk);
      if (irq[1] !== (m_cnt == tgt)) mism++;
      if (irq[1]) pulses++;
    end
    chk("R5 edge irq only in match cycle", mism, 0);
    chk("R5 single pulse", pulses, 1);
    rd(8'h08, d);
    chk("R5 edge leaves status clear", d[1], 0);

    // R6: level style on timer 2
    wr(ta(2, 0), 32'h3);
    tgt = m_cnt + 64'd20;
    wr_cmp(2, tgt);
    while (m_cnt != tgt) @(negedge clk);
    chk("R6 level irq not yet in match cycle", irq[2], 0);
    @(negedge clk);
    chk("R6 level irq after match", irq[2], 1);
    rd(8'h08, d);
    chk("R6 status bit set", d, 32'h4);
    repeat (5) @(negedge clk);
    chk("R6 level irq held", irq[2], 1);
    wr(8'h08, 32'h3);
    rd(8'h08, d);
    chk("R6 zero bits leave status", d, 32'h4);
    wr(8'h08, 32'h4);
    rd(8'h08, d);
    chk("R6 write one clears status", d, 0);
    chk("R6 irq drops after clear", irq[2], 0);

    // R7: clear on the exact match cycle
    tgt = m_cnt + 64'd20;
    wr_cmp(2, tgt);
    while (m_cnt != tgt) @(negedge clk);
    wr(8'h08, 32'h4);
    rd(8'h08, d);
    chk("R7 match beats clear", d[2], 1);
    chk("R7 irq stays high", irq[2], 1);
    wr(8'h08, 32'h4);

    // R8: periodic timer 0, counter restarted at 0
    wr(8'h00, 32'h0);
    wr(8'h10, 32'h0);
    wr(8'h14, 32'h0);
    wr(ta(0, 0), 32'h5);
    wr_cmp(0, 64'd7);
    wr(8'h00, 32'h1);
    mism = 0; pulses = 0;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      if (irq[0] !== (m_cnt != 0 && m_cnt % 7 == 0)) mism++;
      if (irq[0]) pulses++;
    end
    chk("R8 periodic matches every period", mism, 0);
    chk("R8 periodic pulse count", pulses, 40 / 7);
    v = m_cnt;
    rd(ta(0, 4), d);
    chk("R8 comparator shows next match", d, ((v + 6) / 7) * 7);
    rd(ta(0, 0), d);
    chk("R8 timer 0 config readback", d, 5);
    wr(ta(1, 0), 32'h4);
    rd(ta(1, 0), d);
    chk("R8 periodic bit absent on timer 1", d, 0);
    wr(ta(0, 0), 32'h0);

    // R9: 32-bit mode on timer 1
    wr(8'h00, 32'h0);
    wr(8'h10, 32'd100);
    wr(8'h14, 32'd5);
    wr(ta(1, 0), 32'h9);
    wr(ta(1, 8), 32'hFFFF);
    rd(ta(1, 8), d);
    chk("R9 comparator high reads zero", d, 0);
    rd(ta(1, 0), d);
    chk("R9 config readback", d, 9);
    wr(ta(1, 4), 32'd130);
    wr(8'h00, 32'h1);
    mism = 0; pulses = 0;
    for (int k = 0; k < 50; k++) begin
      @(negedge clk);
      if (irq[1] !== (m_cnt[31:0] == 32'd130)) mism++;
      if (irq[1]) pulses++;
    end
    chk("R9 match on low half only", mism, 0);
    chk("R9 one narrow pulse", pulses, 1);

    // R4 / R2: stopped counter gives no event
    wr(8'h00, 32'h0);
    wr(ta(2, 0), 32'h3);
    wr_cmp(2, m_cnt);
    rd_cnt(v);
    repeat (5) @(negedge clk);
    rd_cnt(v2);
    chk("R2 counter holds when stopped", v2, v);
    chk("R2 held value matches model", v2, m_cnt);
    rd(8'h08, d);
    chk("R4 no status while stopped", d, 0);
    chk("R4 no irq while stopped", irq, 0);

    // R4: disabled timer gives no event
    wr(ta(2, 0), 32'h2);
    tgt = m_cnt + 64'd10;
    wr_cmp(2, tgt);
    wr(8'h00, 32'h1);
    mism = 0;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      if (irq[2] !== 1'b0) mism++;
    end
    chk("R4 disabled timer silent", mism, 0);
    rd(8'h08, d);
    chk("R4 disabled timer no status", d, 0);

    done = 1;
    summary();
    $finish;
  end
endmodule